// File: doc/BRIEF.md
# Serial Probe Address Loader

This block is a diagnostic controller placed beside an array of internal nodes. The nodes are arranged as a grid of `ROWS` x `COLS` cells. While the debug-enable input `mode` is high, a host shifts a fixed-order frame in on `sdi`, one bit per rising edge of `dclk`. The frame holds a 10-bit sync pattern, a 21-bit control word, a block of filler bits and four one-hot address fields, and it ends with a stop bit. When the stop bit arrives, the decoded row and column of each probe are committed. From then on, the addressed node is driven in real time onto probe pin `pra` or probe pin `prb`.

The block samples `dclk` and `sdi` in the `clk` domain. It detects the rising edges of `dclk` itself, so `clk` must run at least three times faster than `dclk`. While `mode` is low, the two probe pins carry the ordinary user outputs `usr_a` and `usr_b`, and the loader restarts.

The parser is one state machine with these states:
- `ST_SYNC`: collects the sync pattern.
- `ST_CTRL`: collects the control word.
- `ST_FILL`: skips the filler bits.
- `ST_XB` and `ST_YB`: collect the row and column address for probe B.
- `ST_XA` and `ST_YA`: collect the row and column address for probe A.
- `ST_STOP`: takes the stop bit.
- `ST_REJECT`: absorbs a frame whose sync pattern did not match.

Each field state moves to the next one when the last bit of its field is sampled. `ST_SYNC` goes to `ST_CTRL` when the pattern matches and to `ST_REJECT` when it does not. `ST_STOP` commits the frame and returns to `ST_SYNC`, ready for the next frame. `mode` low forces the parser to `ST_SYNC` from any state. `ST_REJECT` is left only through that path.

Top module: `spal_probe_loader`

## Requirements
- R1: A bit is taken from `sdi` only on a rising edge of `dclk` seen while `mode` is high. `dclk` edges while `mode` is low are ignored, and so are changes on `sdi` between edges.
- R2: The frame is received in this order: `SYNC_PAT` with its most significant bit first, 21 control bits, `FILL` filler bits whose values are ignored, `ROWS` bits of the probe-B row, `COLS` bits of the probe-B column, `ROWS` bits of the probe-A row, `COLS` bits of the probe-A column, and one stop bit. The total length is 32 + `FILL` + 2·(`ROWS`+`COLS`) bits.
- R3: If the received sync field differs from `SYNC_PAT`, both probes are disabled at once. Every later bit is ignored until `mode` goes low.
- R4: Control bit 7 enables probe A and control bit 8 enables probe B, counting the first received control bit as 0. All other control bits are ignored.
- R5: In each address field, the bit received k-th (counting from 0) selects row or column k. A committed probe drives node index row·`COLS`+column of `nodes` onto its pin.
- R6: An address field that does not have exactly one bit set disables only the probe it belongs to.
- R7: A disabled probe drives 0 while `mode` is high. After reset, both probes are disabled.
- R8: A frame takes effect only when its stop bit is received, and the stop bit may be 0 or 1. Until then, the previously committed selection keeps driving the pins, even while a new frame is being shifted in.
- R9: An enabled probe pin follows its selected node with no clock delay.
- R10: While `mode` is low, `pra` = `usr_a` and `prb` = `usr_b`, the parser returns to the start of a frame, and both probe enables are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples `dclk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 1 | Debug enable; high hands the pins to the probes |
| dclk | input | 1 | Serial shift clock, sampled in the `clk` domain |
| sdi | input | 1 | Serial frame data |
| nodes | input | ROWS*COLS | Observable internal nodes, index row·COLS+column |
| usr_a | input | 1 | User output shown on `pra` while `mode` is low |
| usr_b | input | 1 | User output shown on `prb` while `mode` is low |
| pra | output | 1 | Probe A pin |
| prb | output | 1 | Probe B pin |

## Verification
The embedded assertions check these properties on every cycle:
- the parser holds still without a sampled edge;
- the field bit counter stays within its field;
- the reject state is sticky, and a rejected frame disables both probes;
- `mode` low restarts the parser and clears both enables;
- an enable rises only when a stop bit commits a frame;
- a disabled probe reads 0.

The bench scenarios cover what no single-cycle property can show:
- the bit order inside each field, and the mapping from address bits to node index, including the corner cells;
- the effect of each control-word value, with non-enable bits ignored;
- rejection of a malformed address for one probe while the other probe keeps working;
- retargeting through a second frame, with the old selection still live partway through it;
- recovery after a bad sync pattern.

// File: rtl/spal_pkg.sv
package spal_pkg;

    typedef enum logic [3:0] {
        ST_SYNC,
        ST_CTRL,
        ST_FILL,
        ST_XB,
        ST_YB,
        ST_XA,
        ST_YA,
        ST_STOP,
        ST_REJECT
    } spal_state_e;

    localparam int SYNC_W   = 10;
    localparam int CTRL_W   = 21;
    localparam int EN_A_POS = 7;
    localparam int EN_B_POS = 8;

endpackage

// File: rtl/spal_frame_fsm.sv
module spal_frame_fsm
    import spal_pkg::*;
#(
    parameter int ROWS = 13,
    parameter int COLS = 46,
    parameter int FILL = 308,
    parameter logic [SYNC_W-1:0] SYNC_PAT = 10'b1101011010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode,
    input  logic              dclk,
    input  logic              sdi,
    output logic [CTRL_W-1:0] ctrl_sr,
    output logic [ROWS-1:0]   xa_sr,
    output logic [COLS-1:0]   ya_sr,
    output logic [ROWS-1:0]   xb_sr,
    output logic [COLS-1:0]   yb_sr,
    output logic              commit_stb,
    output logic              reject_stb
);

    localparam int CW = $clog2(FILL + CTRL_W + ROWS + COLS + 1);

    spal_state_e       state, nxt;
    logic [CW-1:0]     bitcnt, bitcnt_nxt;
    logic [SYNC_W-1:0] sync_sr;
    logic              dclk_q;
    logic              rise;
    logic              last;
    logic              sync_ok;

    function automatic int flen(spal_state_e s);
        case (s)
            ST_SYNC: return SYNC_W;
            ST_CTRL: return CTRL_W;
            ST_FILL: return FILL;
            ST_XB:   return ROWS;
            ST_YB:   return COLS;
            ST_XA:   return ROWS;
            ST_YA:   return COLS;
            default: return 1;
        endcase
    endfunction

    assign rise    = mode && dclk && !dclk_q;
    assign last    = (int'(bitcnt) == flen(state) - 1);
    assign sync_ok = ({sync_sr[SYNC_W-2:0], sdi} == SYNC_PAT);

    // edge detector; idle level of dclk is high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dclk_q <= 1'b1;
        else        dclk_q <= dclk;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_SYNC;
            bitcnt <= '0;
        end else begin
            state  <= nxt;
            bitcnt <= bitcnt_nxt;
        end
    end

    // next state
    always_comb begin
        nxt        = state;
        bitcnt_nxt = bitcnt;
        if (!mode) begin
            nxt        = ST_SYNC;
            bitcnt_nxt = '0;
        end else if (rise) begin
            bitcnt_nxt = last ? '0 : bitcnt + 1'b1;
            unique case (state)
                ST_SYNC:   if (last) nxt = sync_ok ? ST_CTRL : ST_REJECT;
                ST_CTRL:   if (last) nxt = ST_FILL;
                ST_FILL:   if (last) nxt = ST_XB;
                ST_XB:     if (last) nxt = ST_YB;
                ST_YB:     if (last) nxt = ST_XA;
                ST_XA:     if (last) nxt = ST_YA;
                ST_YA:     if (last) nxt = ST_STOP;
                ST_STOP:   nxt = ST_SYNC;
                ST_REJECT: nxt = ST_REJECT;
                default:   nxt = ST_SYNC;
            endcase
        end
    end

    // outputs
    always_comb begin
        commit_stb = rise && (state == ST_STOP);
        reject_stb = rise && (state == ST_SYNC) && last && !sync_ok;
    end

    // field capture; the k-th arriving bit ends at index k (sync: MSB first)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_sr <= '0;
            ctrl_sr <= '0;
            xa_sr   <= '0;
            ya_sr   <= '0;
            xb_sr   <= '0;
            yb_sr   <= '0;
        end else if (rise) begin
            case (state)
                ST_SYNC: sync_sr <= {sync_sr[SYNC_W-2:0], sdi};
                ST_CTRL: ctrl_sr <= {sdi, ctrl_sr[CTRL_W-1:1]};
                ST_XB:   xb_sr   <= {sdi, xb_sr[ROWS-1:1]};
                ST_YB:   yb_sr   <= {sdi, yb_sr[COLS-1:1]};
                ST_XA:   xa_sr   <= {sdi, xa_sr[ROWS-1:1]};
                ST_YA:   ya_sr   <= {sdi, ya_sr[COLS-1:1]};
                default: ;
            endcase
        end
    end

    p_no_edge_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && !(dclk && !dclk_q)) |=> $stable(state));

    p_count_in_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(bitcnt) < flen(state));

    p_reject_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REJECT && mode) |=> (state == ST_REJECT));

    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |=> (state == ST_SYNC && bitcnt == '0));

endmodule

// File: rtl/spal_onehot_dec.sv
module spal_onehot_dec #(
    parameter int W  = 13,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          valid,
    output logic [IW-1:0] idx
);

    logic seen, multi;

    always_comb begin
        seen  = 1'b0;
        multi = 1'b0;
        idx   = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                if (seen) multi = 1'b1;
                seen = 1'b1;
                idx  = IW'(i);
            end
        end
        valid = seen && !multi;
    end

endmodule

// File: rtl/spal_probe_mux.sv
module spal_probe_mux #(
    parameter int ROWS = 13,
    parameter int COLS = 46,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CLW = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int NW = $clog2(ROWS * COLS + 1)
) (
    input  logic [ROWS*COLS-1:0] nodes,
    input  logic                 en,
    input  logic [RW-1:0]        row,
    input  logic [CLW-1:0]       col,
    output logic                 pin
);

    logic [NW-1:0] flat;

    always_comb begin
        flat = NW'(row) * NW'(COLS) + NW'(col);
        pin  = en && nodes[flat];
    end

endmodule

// File: rtl/spal_probe_loader.sv
module spal_probe_loader
    import spal_pkg::*;
#(
    parameter int ROWS = 13,
    parameter int COLS = 46,
    parameter int FILL = 308,
    parameter logic [SYNC_W-1:0] SYNC_PAT = 10'b1101011010
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode,
    input  logic                 dclk,
    input  logic                 sdi,
    input  logic [ROWS*COLS-1:0] nodes,
    input  logic                 usr_a,
    input  logic                 usr_b,
    output logic                 pra,
    output logic                 prb
);

    localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int CLW = (COLS > 1) ? $clog2(COLS) : 1;
    localparam int NPROBE = 2;

    logic [CTRL_W-1:0] ctrl_sr;
    logic [ROWS-1:0]   x_sr [NPROBE];
    logic [COLS-1:0]   y_sr [NPROBE];
    logic              commit_stb, reject_stb;

    logic [NPROBE-1:0] en;
    logic [NPROBE-1:0] probe_pin;

    spal_frame_fsm #(
        .ROWS(ROWS), .COLS(COLS), .FILL(FILL), .SYNC_PAT(SYNC_PAT)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .dclk       (dclk),
        .sdi        (sdi),
        .ctrl_sr    (ctrl_sr),
        .xa_sr      (x_sr[0]),
        .ya_sr      (y_sr[0]),
        .xb_sr      (x_sr[1]),
        .yb_sr      (y_sr[1]),
        .commit_stb (commit_stb),
        .reject_stb (reject_stb)
    );

    // probe 0 = A (pin pra), probe 1 = B (pin prb)
    for (genvar p = 0; p < NPROBE; p++) begin : g_probe
        localparam int CTRL_POS = (p == 0) ? EN_A_POS : EN_B_POS;

        logic           row_ok, col_ok;
        logic [RW-1:0]  row_dec, row_q;
        logic [CLW-1:0] col_dec, col_q;

        spal_onehot_dec #(.W(ROWS)) u_row (
            .vec(x_sr[p]), .valid(row_ok), .idx(row_dec));
        spal_onehot_dec #(.W(COLS)) u_col (
            .vec(y_sr[p]), .valid(col_ok), .idx(col_dec));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en[p] <= 1'b0;
                row_q <= '0;
                col_q <= '0;
            end else if (!mode || reject_stb) begin
                en[p] <= 1'b0;
            end else if (commit_stb) begin
                en[p] <= ctrl_sr[CTRL_POS] && row_ok && col_ok;
                row_q <= row_dec;
                col_q <= col_dec;
            end
        end

        spal_probe_mux #(.ROWS(ROWS), .COLS(COLS)) u_mux (
            .nodes (nodes),
            .en    (en[p]),
            .row   (row_q),
            .col   (col_q),
            .pin   (probe_pin[p])
        );
    end

    assign pra = mode ? probe_pin[0] : usr_a;
    assign prb = mode ? probe_pin[1] : usr_b;

    p_enable_on_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(en[0]) || $rose(en[1])) |-> $past(commit_stb));

    p_reject_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reject_stb |=> (en == '0));

    p_mode_low_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |=> (en == '0));

    p_off_drives_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && !en[0]) |-> !pra);

endmodule

// File: tb/tb_spal_probe_loader.sv
module tb_spal_probe_loader;

    localparam int R  = 13;
    localparam int C  = 46;
    localparam int N  = 308;
    localparam int FL = 32 + N + 2 * (R + C);
    localparam logic [9:0]  SYNC   = 10'b1101011010;
    localparam logic [20:0] CW_A   = 21'b000000110001111100000;
    localparam logic [20:0] CW_B   = 21'b000000101001111100000;
    localparam logic [20:0] CW_AB  = 21'b000000111001111100000;
    localparam logic [20:0] CW_AX  = 21'b111111110111111111111;

    // vector table: control select (0 A, 1 B, 2 both), A row/col, B row/col
    localparam int NV = 6;
    localparam int V_SEL[NV] = '{2, 0, 1, 2, 2, 0};
    localparam int V_RA [NV] = '{0, 12, 5, 12, 0, 7};
    localparam int V_CA [NV] = '{0, 45, 3, 0, 45, 20};
    localparam int V_RB [NV] = '{12, 1, 0, 0, 6, 2};
    localparam int V_CB [NV] = '{45, 2, 0, 45, 10, 44};

    logic clk = 0;
    logic rst_n = 0;
    logic mode = 0;
    logic dclk = 1;
    logic sdi = 0;
    logic [R*C-1:0] nodes = '0;
    logic usr_a = 0, usr_b = 0;
    logic pra, prb;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    spal_probe_loader #(.ROWS(R), .COLS(C), .FILL(N), .SYNC_PAT(SYNC)) dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .dclk(dclk), .sdi(sdi),
        .nodes(nodes), .usr_a(usr_a), .usr_b(usr_b), .pra(pra), .prb(prb));

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0b exp=%0b", req, act, exp);
        end
    endtask

    function automatic logic [R-1:0] ohr(input int i);
        logic [R-1:0] v = '0;
        v[i] = 1'b1;
        return v;
    endfunction

    function automatic logic [C-1:0] ohc(input int i);
        logic [C-1:0] v = '0;
        v[i] = 1'b1;
        return v;
    endfunction

    function automatic logic [FL-1:0] mk(input logic [9:0] sw, input logic [20:0] cw,
                                         input logic [R-1:0] xb, input logic [C-1:0] yb,
                                         input logic [R-1:0] xa, input logic [C-1:0] ya,
                                         input logic sb, input logic fillv);
        logic [FL-1:0] f = '0;
        int p = 0;
        for (int i = 9; i >= 0; i--) begin f[p] = sw[i]; p = p + 1; end
        for (int i = 20; i >= 0; i--) begin f[p] = cw[i]; p = p + 1; end
        for (int i = 0; i < N; i++) begin f[p] = fillv; p = p + 1; end
        for (int i = 0; i < R; i++) begin f[p] = xb[i]; p = p + 1; end
        for (int i = 0; i < C; i++) begin f[p] = yb[i]; p = p + 1; end
        for (int i = 0; i < R; i++) begin f[p] = xa[i]; p = p + 1; end
        for (int i = 0; i < C; i++) begin f[p] = ya[i]; p = p + 1; end
        f[p] = sb;
        return f;
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk);
        sdi  = b;
        dclk = 0;
        repeat (2) @(negedge clk);
        dclk = 1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_bits(input logic [FL-1:0] f, input int from, input int upto);
        for (int i = from; i < upto; i++) send_bit(f[i]);
    endtask

    task automatic mode_cycle();
        @(negedge clk); mode = 0;
        repeat (3) @(negedge clk); mode = 1;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [20:0] cw_of(input int s);
        return (s == 0) ? CW_A : (s == 1) ? CW_B : CW_AB;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [FL-1:0] f;
        logic ea, eb;
        usr_a = 1;
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        // R10: user outputs while mode low
        chk("R10 usr_a passthrough", pra, 1'b1);
        chk("R10 usr_b passthrough", prb, 1'b0);
        // R1: full valid frame with mode low must be ignored
        nodes = '1;
        send_bits(mk(SYNC, CW_AB, ohr(0), ohc(0), ohr(0), ohc(0), 1'b0, 1'b0), 0, FL);
        mode = 1;
        repeat (2) @(negedge clk);
        chk("R7 reset pra off", pra, 1'b0);
        chk("R1 frame with mode low ignored", prb, 1'b0);

        // table walk: R2 R4 R5 R9
        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < R * C; i++) nodes[i] = ((i * 7 + v) % 3) == 0;
            f = mk(SYNC, cw_of(V_SEL[v]), ohr(V_RB[v]), ohc(V_CB[v]),
                   ohr(V_RA[v]), ohc(V_CA[v]), v[0], v[1]);
            send_bits(f, 0, FL);
            ea = (V_SEL[v] != 1);
            eb = (V_SEL[v] != 0);
            chk("R5 pra selected node", pra, ea & nodes[V_RA[v] * C + V_CA[v]]);
            chk("R5 prb selected node", prb, eb & nodes[V_RB[v] * C + V_CB[v]]);
            @(negedge clk);
            nodes = ~nodes;
            #1;
            chk("R9 pra follows node", pra, ea & nodes[V_RA[v] * C + V_CA[v]]);
            chk("R4 prb enable bit", prb, eb & nodes[V_RB[v] * C + V_CB[v]]);
        end

        // R4: non-enable control bits ignored
        nodes = '0;
        nodes[3 * C + 4] = 1'b1;
        nodes[4 * C + 3] = 1'b1;
        send_bits(mk(SYNC, CW_AX, ohr(4), ohc(3), ohr(3), ohc(4), 1'b1, 1'b1), 0, FL);
        chk("R4 A enabled by bit 7", pra, 1'b1);
        chk("R4 B off by bit 8", prb, 1'b0);

        // R6: bad row for A (all zero) while B valid
        send_bits(mk(SYNC, CW_AB, ohr(4), ohc(3), '0, ohc(4), 1'b0, 1'b0), 0, FL);
        chk("R6 A zero row disables A", pra, 1'b0);
        chk("R6 B unaffected", prb, 1'b1);
        // R6: two-hot column for B
        send_bits(mk(SYNC, CW_AB, ohr(4), ohc(3) | ohc(5), ohr(3), ohc(4), 1'b0, 1'b0), 0, FL);
        chk("R6 B two-hot column disables B", prb, 1'b0);
        chk("R6 A unaffected", pra, 1'b1);

        // R8: retarget, old selection live during load
        nodes = '0;
        nodes[1 * C + 1] = 1'b1;
        send_bits(mk(SYNC, CW_A, ohr(0), ohc(0), ohr(1), ohc(1), 1'b0, 1'b0), 0, FL);
        chk("R8 first target", pra, 1'b1);
        f = mk(SYNC, CW_A, ohr(0), ohc(0), ohr(2), ohc(2), 1'b1, 1'b0);
        send_bits(f, 0, FL - 1);
        chk("R8 old target kept before stop", pra, 1'b1);
        send_bits(f, FL - 1, FL);
        chk("R8 new target after stop bit 1", pra, 1'b0);
        @(negedge clk);
        nodes[2 * C + 2] = 1'b1;
        #1;
        chk("R8 new target node", pra, 1'b1);

        // R3: bad sync rejects and is sticky
        nodes = '1;
        send_bits(mk(10'b0, CW_AB, ohr(0), ohc(0), ohr(0), ohc(0), 1'b0, 1'b0), 0, FL);
        chk("R3 bad sync A off", pra, 1'b0);
        chk("R3 bad sync B off", prb, 1'b0);
        send_bits(mk(SYNC, CW_AB, ohr(0), ohc(0), ohr(0), ohc(0), 1'b0, 1'b0), 0, FL);
        chk("R3 reject sticky", pra, 1'b0);
        mode_cycle();
        send_bits(mk(SYNC, CW_AB, ohr(0), ohc(0), ohr(0), ohc(0), 1'b0, 1'b0), 0, FL);
        chk("R3 recovery after mode low", pra, 1'b1);
        chk("R2 recovery B", prb, 1'b1);

        // R10: mode low mid-frame restarts parser and clears enables
        f = mk(SYNC, CW_AB, ohr(1), ohc(1), ohr(1), ohc(1), 1'b0, 1'b0);
        send_bits(f, 0, 100);
        @(negedge clk); mode = 0; usr_a = 0; usr_b = 1;
        repeat (2) @(negedge clk);
        chk("R10 pra = usr_a", pra, 1'b0);
        chk("R10 prb = usr_b", prb, 1'b1);
        mode = 1;
        repeat (2) @(negedge clk);
        chk("R10 enables cleared", pra, 1'b0);
        send_bits(f, 0, FL);
        chk("R10 parser restarted", prb, 1'b1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule